// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of page-table entries for a memory-management unit. Each slot holds a virtual page tag, an address-space identifier, a physical page number, per-privilege-mode read and write enable masks, and fault-on-read and fault-on-write flags. It also holds a global flag that makes the entry visible to every address space. A lookup port compares the requested page and address space against all slots in the same cycle. It returns a hit flag, the index of the winning slot and that slot's fields.

Maintenance goes through a registered command port, which acts on the next rising clock edge. The commands are insert, pointer advance and three kinds of invalidation: everything, every non-global entry (used on a context switch), or one page within one address space. New entries always go to the slot under a round-robin replacement pointer. An index-query port shows the slot under that pointer at all times.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, the replacement pointer is 0, the lookup reports no hit and the index-query port reports an invalid slot.
- R2: A lookup hits only a valid slot whose tag equals the requested page and whose stored address space equals the requested one or whose global flag is set; a non-global slot with a different address space misses.
- R3: When several slots hit, the lookup returns the one with the lowest index.
- R4: Command code 1 (insert) writes page, address space, physical page, both enable masks, both fault flags and the global flag into the slot under the pointer and marks it valid; from the next cycle a lookup returns those fields.
- R5: Each insert (code 1) or advance (code 2) moves the pointer up by one, wrapping from ENTRIES-1 to 0; code 0 (idle) and the flush codes leave it unchanged.
- R6: Code 2 (advance) moves the pointer without changing any slot; the index-query port always shows the pointer, the valid bit, the tag and the physical page of the slot under it.
- R7: Code 3 (flush all) invalidates and clears every slot.
- R8: Code 4 (flush process) invalidates every non-global slot and leaves global slots usable.
- R9: Code 5 (flush address) invalidates each valid slot whose tag equals the given page and whose address space equals the given one or whose global flag is set; other slots stay.
- R10: A lookup in the same cycle as a command sees the contents from before that command.
- R11: An insert over a valid slot replaces its old mapping, which then no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Command: 0 idle, 1 insert, 2 advance, 3 flush all, 4 flush process, 5 flush address |
| op_vpn | input | VPN_W | Page for insert or flush address |
| op_asn | input | ASN_W | Address space for insert or flush address |
| op_ppn | input | PPN_W | Physical page for insert |
| op_rd_en | input | MODES | Per-mode read enable for insert |
| op_wr_en | input | MODES | Per-mode write enable for insert |
| op_fault_rd | input | 1 | Fault-on-read flag for insert |
| op_fault_wr | input | 1 | Fault-on-write flag for insert |
| op_global | input | 1 | Global flag for insert |
| lk_vpn | input | VPN_W | Lookup page |
| lk_asn | input | ASN_W | Lookup address space |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the hitting slot |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_rd_en | output | MODES | Read enable mask of the hit |
| lk_wr_en | output | MODES | Write enable mask of the hit |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit |
| lk_global | output | 1 | Global flag of the hit |
| rp_ptr | output | IDX_W | Replacement pointer |
| rp_valid | output | 1 | Valid bit of the slot under the pointer |
| rp_vpn | output | VPN_W | Tag of the slot under the pointer |
| rp_ppn | output | PPN_W | Physical page of the slot under the pointer |

## Verification
Lookups are tried with a matching address space, a mismatching one against a non-global slot, and any address space against a global slot, which separates the tag compare from the address-space qualifier. A duplicate page in two slots tells lowest-index priority from replacement order. An insert after the pointer wraps tells overwrite from append. Flush-address is tried with an address-space match, a global match and a mismatch. Flush-process is run over a mix of global and private slots, and a lookup held through a flush shows that lookups see the contents from before the command.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;
   typedef enum logic [2:0] {
      TLB_IDLE       = 3'd0,
      TLB_INSERT     = 3'd1,
      TLB_ADVANCE    = 3'd2,
      TLB_FLUSH_ALL  = 3'd3,
      TLB_FLUSH_PROC = 3'd4,
      TLB_FLUSH_ADDR = 3'd5
   } tlb_cmd_e;
endpackage

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr #(
   parameter int ENTRIES = 48,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (step)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   // R5: the pointer never leaves the slot range
   p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
   // R5: no step, no movement
   p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(ptr));
endmodule

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
   parameter int ENTRIES = 48,
   parameter int VPN_W   = 30,
   parameter int ASN_W   = 8
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0]            glb,
   input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
   input  logic [ENTRIES-1:0][ASN_W-1:0] asns,
   input  logic [VPN_W-1:0]              q_vpn,
   input  logic [ASN_W-1:0]              q_asn,
   output logic [ENTRIES-1:0]            match
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign match[g] = valid[g] && (tags[g] == q_vpn) &&
                        (glb[g] || (asns[g] == q_asn));
   end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int ENTRIES = 48,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ENTRIES-1:0] match,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!any && match[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

   logic [ENTRIES-1:0] below_sel;
   assign below_sel = ({{(ENTRIES-1){1'b0}}, 1'b1} << idx) - 1'b1;

   // R3: the chosen slot matches and no lower slot does
   p_lowest_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (match[idx] && ((match & below_sel) == '0)));
   // R3: hit reported exactly when some slot matches
   p_any_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any == (match != '0));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
   import asn_tlb_pkg::*;
#(
   parameter int ENTRIES = 48,
   parameter int VPN_W   = 30,
   parameter int ASN_W   = 8,
   parameter int PPN_W   = 28,
   parameter int MODES   = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op_code,
   input  logic [VPN_W-1:0] op_vpn,
   input  logic [ASN_W-1:0] op_asn,
   input  logic [PPN_W-1:0] op_ppn,
   input  logic [MODES-1:0] op_rd_en,
   input  logic [MODES-1:0] op_wr_en,
   input  logic             op_fault_rd,
   input  logic             op_fault_wr,
   input  logic             op_global,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [ASN_W-1:0] lk_asn,
   output logic             lk_hit,
   output logic [IDX_W-1:0] lk_idx,
   output logic [PPN_W-1:0] lk_ppn,
   output logic [MODES-1:0] lk_rd_en,
   output logic [MODES-1:0] lk_wr_en,
   output logic             lk_fault_rd,
   output logic             lk_fault_wr,
   output logic             lk_global,
   output logic [IDX_W-1:0] rp_ptr,
   output logic             rp_valid,
   output logic [VPN_W-1:0] rp_vpn,
   output logic [PPN_W-1:0] rp_ppn
);
   initial begin
      if (ENTRIES < 2)  $error("asn_tlb: ENTRIES must be at least 2");
      if (VPN_W < 1 || ASN_W < 1 || PPN_W < 1) $error("asn_tlb: field widths must be positive");
      if (MODES < 1)    $error("asn_tlb: MODES must be at least 1");
   end

   tlb_cmd_e cmd;
   assign cmd = tlb_cmd_e'(op_code);

   logic [ENTRIES-1:0]            vld_q, glb_q, frd_q, fwr_q;
   logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
   logic [ENTRIES-1:0][ASN_W-1:0] asn_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   logic [ENTRIES-1:0][MODES-1:0] ren_q, wen_q;

   logic [ENTRIES-1:0] lk_match, fa_match;
   logic               ptr_step;

   assign ptr_step = (cmd == TLB_INSERT) || (cmd == TLB_ADVANCE);

   tlb_repl_ptr #(.ENTRIES(ENTRIES)) i_ptr (
      .clk(clk), .rst_n(rst_n), .step(ptr_step), .ptr(rp_ptr));

   tlb_tag_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) i_lk_cmp (
      .valid(vld_q), .glb(glb_q), .tags(tag_q), .asns(asn_q),
      .q_vpn(lk_vpn), .q_asn(lk_asn), .match(lk_match));

   tlb_tag_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) i_fa_cmp (
      .valid(vld_q), .glb(glb_q), .tags(tag_q), .asns(asn_q),
      .q_vpn(op_vpn), .q_asn(op_asn), .match(fa_match));

   tlb_first_hit #(.ENTRIES(ENTRIES)) i_sel (
      .clk(clk), .rst_n(rst_n), .match(lk_match), .any(lk_hit), .idx(lk_idx));

   // valid bits: reset and all commands
   always_ff @(posedge clk) begin
      if (!rst_n)
         vld_q <= '0;
      else begin
         case (cmd)
            TLB_INSERT:     vld_q[rp_ptr] <= 1'b1;
            TLB_FLUSH_ALL:  vld_q <= '0;
            TLB_FLUSH_PROC: vld_q <= vld_q & glb_q;
            TLB_FLUSH_ADDR: vld_q <= vld_q & ~fa_match;
            default: ;
         endcase
      end
   end

   // payload: written by insert, cleared by flush-all
   always_ff @(posedge clk) begin
      if (cmd == TLB_INSERT) begin
         tag_q[rp_ptr] <= op_vpn;
         asn_q[rp_ptr] <= op_asn;
         ppn_q[rp_ptr] <= op_ppn;
         ren_q[rp_ptr] <= op_rd_en;
         wen_q[rp_ptr] <= op_wr_en;
         frd_q[rp_ptr] <= op_fault_rd;
         fwr_q[rp_ptr] <= op_fault_wr;
         glb_q[rp_ptr] <= op_global;
      end else if (cmd == TLB_FLUSH_ALL) begin
         tag_q <= '0;
         asn_q <= '0;
         ppn_q <= '0;
         ren_q <= '0;
         wen_q <= '0;
         frd_q <= '0;
         fwr_q <= '0;
         glb_q <= '0;
      end
   end

   assign lk_ppn      = ppn_q[lk_idx];
   assign lk_rd_en    = ren_q[lk_idx];
   assign lk_wr_en    = wen_q[lk_idx];
   assign lk_fault_rd = frd_q[lk_idx];
   assign lk_fault_wr = fwr_q[lk_idx];
   assign lk_global   = glb_q[lk_idx];

   assign rp_valid = vld_q[rp_ptr];
   assign rp_vpn   = tag_q[rp_ptr];
   assign rp_ppn   = ppn_q[rp_ptr];

   // R2: a reported hit is a valid slot with matching tag and space or global
   p_hit_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (vld_q[lk_idx] && tag_q[lk_idx] == lk_vpn &&
                  (glb_q[lk_idx] || asn_q[lk_idx] == lk_asn)));
   // R4: the inserted slot is valid and carries the new tag
   p_insert_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == TLB_INSERT |=> (vld_q[$past(rp_ptr)] && tag_q[$past(rp_ptr)] == $past(op_vpn)));
   // R7: nothing survives flush-all
   p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == TLB_FLUSH_ALL |=> vld_q == '0);
   // R8: only global slots survive flush-process
   p_flush_proc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == TLB_FLUSH_PROC |=> (vld_q & ~glb_q) == '0 && vld_q == ($past(vld_q) & $past(glb_q)));
   // R9: matched slots are gone after flush-address
   p_flush_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == TLB_FLUSH_ADDR |=> (vld_q & $past(fa_match)) == '0);
   // R6: advance leaves every valid bit alone
   p_advance_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == TLB_ADVANCE |=> $stable(vld_q));
endmodule

// File: tb/test_asn_tlb.sv
module test_asn_tlb;
   localparam int ENTRIES = 4;
   localparam int VPN_W = 20, ASN_W = 8, PPN_W = 20, MODES = 4;
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int NVEC = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0]       op_code = '0;
   logic [VPN_W-1:0] op_vpn = '0;
   logic [ASN_W-1:0] op_asn = '0;
   logic [PPN_W-1:0] op_ppn = '0;
   logic [MODES-1:0] op_rd_en = '0, op_wr_en = '0;
   logic             op_fault_rd = 1'b0, op_fault_wr = 1'b0, op_global = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [ASN_W-1:0] lk_asn = '0;
   logic             lk_hit, lk_fault_rd, lk_fault_wr, lk_global, rp_valid;
   logic [IDX_W-1:0] lk_idx, rp_ptr;
   logic [PPN_W-1:0] lk_ppn, rp_ppn;
   logic [MODES-1:0] lk_rd_en, lk_wr_en;
   logic [VPN_W-1:0] rp_vpn;

   int n_checks = 0;
   int n_fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   asn_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W), .MODES(MODES)) i_asn_tlb (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_vpn(op_vpn), .op_asn(op_asn),
      .op_ppn(op_ppn), .op_rd_en(op_rd_en), .op_wr_en(op_wr_en),
      .op_fault_rd(op_fault_rd), .op_fault_wr(op_fault_wr), .op_global(op_global),
      .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
      .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr), .lk_global(lk_global),
      .rp_ptr(rp_ptr), .rp_valid(rp_valid), .rp_vpn(rp_vpn), .rp_ppn(rp_ppn));

   typedef struct packed {
      logic [2:0]       op;
      logic [VPN_W-1:0] vpn;
      logic [ASN_W-1:0] asn;
      logic [PPN_W-1:0] ppn;
      logic             glb;
      logic [VPN_W-1:0] lvpn;
      logic [ASN_W-1:0] lasn;
      logic             ehit;
      logic [PPN_W-1:0] eppn;
   } vec_t;

   // op: 0 idle, 1 insert, 2 advance, 3 flush all, 4 flush process, 5 flush address
   localparam vec_t VEC [NVEC] = '{
      '{3'd1, 20'h100, 8'd1, 20'hA1, 1'b0, 20'h100, 8'd1, 1'b1, 20'hA1}, //  0 R4 slot0
      '{3'd0, 20'h0,   8'd0, 20'h0,  1'b0, 20'h100, 8'd2, 1'b0, 20'h0 }, //  1 R2 asn mismatch
      '{3'd1, 20'h200, 8'd3, 20'hB2, 1'b1, 20'h200, 8'd7, 1'b1, 20'hB2}, //  2 R2 global slot1
      '{3'd1, 20'h300, 8'd1, 20'hC3, 1'b0, 20'h300, 8'd1, 1'b1, 20'hC3}, //  3 R4 slot2
      '{3'd1, 20'h100, 8'd1, 20'hD4, 1'b0, 20'h100, 8'd1, 1'b1, 20'hA1}, //  4 R3 dup in slot3
      '{3'd1, 20'h400, 8'd2, 20'hE5, 1'b0, 20'h100, 8'd1, 1'b1, 20'hD4}, //  5 R11 wrap over slot0
      '{3'd0, 20'h0,   8'd0, 20'h0,  1'b0, 20'h400, 8'd2, 1'b1, 20'hE5}, //  6 R5 wrapped insert
      '{3'd5, 20'h100, 8'd1, 20'h0,  1'b0, 20'h100, 8'd1, 1'b0, 20'h0 }, //  7 R9 asn match
      '{3'd0, 20'h0,   8'd0, 20'h0,  1'b0, 20'h300, 8'd1, 1'b1, 20'hC3}, //  8 R9 others kept
      '{3'd5, 20'h200, 8'd9, 20'h0,  1'b0, 20'h200, 8'd3, 1'b0, 20'h0 }, //  9 R9 global match
      '{3'd5, 20'h300, 8'd5, 20'h0,  1'b0, 20'h300, 8'd1, 1'b1, 20'hC3}, // 10 R9 mismatch kept
      '{3'd1, 20'h500, 8'd4, 20'hF6, 1'b1, 20'h500, 8'd0, 1'b1, 20'hF6}, // 11 R4 global slot1
      '{3'd4, 20'h0,   8'd0, 20'h0,  1'b0, 20'h500, 8'd0, 1'b1, 20'hF6}, // 12 R8 global kept
      '{3'd0, 20'h0,   8'd0, 20'h0,  1'b0, 20'h300, 8'd1, 1'b0, 20'h0 }, // 13 R8 private gone
      '{3'd3, 20'h0,   8'd0, 20'h0,  1'b0, 20'h500, 8'd0, 1'b0, 20'h0 }  // 14 R7 all gone
   };

   function automatic string vec_tag(int i);
      case (i)
         0, 3, 11: return "R4";
         1, 2:     return "R2";
         4:        return "R3";
         5:        return "R11";
         6:        return "R5";
         7, 8, 9, 10: return "R9";
         12, 13:   return "R8";
         default:  return "R7";
      endcase
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive_op(logic [2:0] c, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a,
                           logic [PPN_W-1:0] p, logic g);
      @(negedge clk);
      op_code = c; op_vpn = v; op_asn = a; op_ppn = p; op_global = g;
      @(negedge clk);
      op_code = 3'd0;
      #1;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      lk_vpn = 20'h0; lk_asn = 8'd0;
      #1;
      chk("R1", "hit during reset", 32'(lk_hit), 0);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R1", "hit after reset", 32'(lk_hit), 0);
      chk("R1", "pointer after reset", 32'(rp_ptr), 0);
      chk("R1", "slot valid after reset", 32'(rp_valid), 0);

      // vector table
      op_rd_en = 4'h3; op_wr_en = 4'h1; op_fault_rd = 1'b0; op_fault_wr = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         lk_vpn = VEC[i].lvpn; lk_asn = VEC[i].lasn;
         drive_op(VEC[i].op, VEC[i].vpn, VEC[i].asn, VEC[i].ppn, VEC[i].glb);
         chk(vec_tag(i), $sformatf("vector %0d hit", i), 32'(lk_hit), 32'(VEC[i].ehit));
         if (VEC[i].ehit)
            chk(vec_tag(i), $sformatf("vector %0d ppn", i), 32'(lk_ppn), 32'(VEC[i].eppn));
      end

      // R5/R6: six inserts leave the pointer at 2; flushes did not move it
      chk("R5", "pointer after inserts and flushes", 32'(rp_ptr), 2);
      drive_op(3'd2, '0, '0, '0, 1'b0);
      chk("R6", "advance to 3", 32'(rp_ptr), 3);
      drive_op(3'd2, '0, '0, '0, 1'b0);
      chk("R5", "advance wraps to 0", 32'(rp_ptr), 0);
      chk("R6", "slot 0 invalid after flush all", 32'(rp_valid), 0);

      // R4: all fields stored and returned
      op_rd_en = 4'hC; op_wr_en = 4'h8; op_fault_rd = 1'b1; op_fault_wr = 1'b0;
      lk_vpn = 20'h777; lk_asn = 8'd2;
      drive_op(3'd1, 20'h777, 8'd2, 20'h12345, 1'b1);
      chk("R4", "field hit", 32'(lk_hit), 1);
      chk("R4", "field idx", 32'(lk_idx), 0);
      chk("R4", "field ppn", 32'(lk_ppn), 32'h12345);
      chk("R4", "field rd_en", 32'(lk_rd_en), 32'hC);
      chk("R4", "field wr_en", 32'(lk_wr_en), 32'h8);
      chk("R4", "field fault_rd", 32'(lk_fault_rd), 1);
      chk("R4", "field fault_wr", 32'(lk_fault_wr), 0);
      chk("R4", "field global", 32'(lk_global), 1);
      chk("R5", "pointer after insert", 32'(rp_ptr), 1);

      // R6: advance around to slot 0 without disturbing it
      for (int k = 0; k < 3; k++) drive_op(3'd2, '0, '0, '0, 1'b0);
      chk("R6", "index query pointer", 32'(rp_ptr), 0);
      chk("R6", "index query valid", 32'(rp_valid), 1);
      chk("R6", "index query vpn", 32'(rp_vpn), 32'h777);
      chk("R6", "index query ppn", 32'(rp_ppn), 32'h12345);
      chk("R6", "lookup unchanged by advance", 32'(lk_hit), 1);

      // R10: lookup during a flush sees old contents
      @(negedge clk);
      op_code = 3'd3;
      #1;
      chk("R10", "hit in flush cycle", 32'(lk_hit), 1);
      @(negedge clk);
      op_code = 3'd0;
      #1;
      chk("R10", "hit after flush", 32'(lk_hit), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule